// File: doc/BRIEF.md
# Time-Base Interval Timer

This block holds a free-running binary up-counter. The counter advances on every clock cycle in which the count-tick enable is high. Software picks one of four counter bits as the interval tap. Each time that bit falls from 1 to 0, the block latches a sticky overflow flag. An interrupt enable bit gates the flag onto a single level-sensitive interrupt request line.

The control register sits on a small synchronous register bus. It holds the flag, the enable, the tap select and an active-low counter-clear strobe. A clear that lands in the same cycle as an overflow wins over the overflow: the counter restarts and the flag is not set. Because the flag is recorded even while the interrupt is disabled, software enables the interrupt and clears a stale flag in one write.

Top module: `ivt_top`

## Requirements
- R1: The counter starts at 0, adds one on each clock edge where `cnt_tick` is 1, holds when `cnt_tick` is 0, and wraps modulo 2^CNT_W.
- R2: Control bits [1:0] (`sel`) choose tap bit TAP_BASE + sel*TAP_STEP. An overflow is a tick that takes that bit from 1 to 0, i.e. a tick while counter bits [tap:0] are all ones. The flag reads 1 from the edge of that tick onward.
- R3: The overflow flag (control bit 7) is set on overflow whether the interrupt enable (control bit 6) is 0 or 1.
- R4: `irq` is 1 exactly when the flag and the enable are both 1. It follows a register write at the next clock edge.
- R5: The flag stays 1 until a control write carries 0 in bit 7. That write clears it and drops `irq`. If an overflow happens in the same cycle as that write, the flag stays 1.
- R6: A write that sets the enable while the flag is 1 raises `irq` at the edge of that write.
- R7: A control write with bit 5 = 0 loads the counter with 0, overriding a tick. An overflow in that same cycle does not set the flag.
- R8: A single write with bit 6 = 1 and bit 7 = 0 (and no overflow in that cycle) leaves `irq` at 0.
- R9: Writing 1 to bit 7 never sets the flag.
- R10: Reading the control address returns {flag, enable, 1, 3'b000, sel}; bit 5 always reads 1. Any other address reads 0, and writes to it change nothing. Read data is combinational from the address.
- R11: After reset the flag, the enable and the counter are 0 and `sel` is 0 (shortest interval), so the control register reads 8'h20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count clock enable; one increment per high cycle |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interval interrupt request, level |

## Verification
Read data depends only on the address and the registers, so it is valid in the same cycle the address is applied. The flag, enable, tap select and counter change at the rising edge that samples a write or a tick. `irq` follows them in the cycle after that edge, with no further delay. The bench drives inputs 1 ns after a rising edge, steps its behavioural model on the next rising edge, and compares `reg_rdata` and `irq` at the following falling edge, so every result is sampled exactly one edge after its cause. The clear-on-overflow and clear-flag-on-overflow collisions are forced by watching the model's count and issuing the write in the cycle where the selected bits are all ones.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int SEL_W    = 2;
    localparam int NUM_TAPS = 1 << SEL_W;
    localparam int DATA_W   = 8;
    // control register field positions
    localparam int FLAG_BIT = 7;
    localparam int IEN_BIT  = 6;
    localparam int CLRN_BIT = 5;

    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic flag;
        logic ien;
        sel_t sel;
    } ctrl_t;
endpackage

// File: rtl/ivt_counter.sv
module ivt_counter
    import ivt_pkg::*;
#(
    parameter int CNT_W    = 22,
    parameter int TAP_BASE = 11,
    parameter int TAP_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  sel_t             sel,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [NUM_TAPS-1:0] wrap;

    // one all-ones detector per selectable tap
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        localparam int POS = TAP_BASE + t * TAP_STEP;
        assign wrap[t] = &st_q.cnt[POS:0];
    end

    always_comb begin
        st_d = st_q;
        ovf  = tick & wrap[sel];
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
    import ivt_pkg::*;
#(
    parameter int              ADDR_W    = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              ovf,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clr,
    output sel_t              sel,
    output logic              flag,
    output logic              ien,
    output logic              irq
);
    ctrl_t st_d, st_q;
    logic  wr, set, sel_hit;
    logic  wdata_unused;

    assign wdata_unused = ^reg_wdata[CLRN_BIT-1:SEL_W];

    always_comb begin
        sel_hit = (reg_addr == CTRL_ADDR);
        wr      = reg_we & sel_hit;
        clr     = wr & ~reg_wdata[CLRN_BIT];
        set     = ovf & ~clr;
        st_d    = st_q;
        if (wr) begin
            st_d.ien = reg_wdata[IEN_BIT];
            st_d.sel = reg_wdata[SEL_W-1:0];
            if (!reg_wdata[FLAG_BIT]) begin
                st_d.flag = 1'b0;
            end
        end
        if (set) begin
            st_d.flag = 1'b1;   // hardware set wins over software clear
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_hit) begin
            reg_rdata[FLAG_BIT]    = st_q.flag;
            reg_rdata[IEN_BIT]     = st_q.ien;
            reg_rdata[CLRN_BIT]    = 1'b1;
            reg_rdata[SEL_W-1:0]   = st_q.sel;
        end
    end

    assign sel  = st_q.sel;
    assign flag = st_q.flag;
    assign ien  = st_q.ien;
    assign irq  = st_q.flag & st_q.ien;
endmodule

// File: rtl/ivt_top.sv
module ivt_top
    import ivt_pkg::*;
#(
    parameter int                CNT_W     = 22,
    parameter int                TAP_BASE  = 11,
    parameter int                TAP_STEP  = 2,
    parameter int                ADDR_W    = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] cnt_w;
    logic             ovf_w, clr_w, flag_w, ien_w;
    sel_t             sel_w;

    ivt_counter #(
        .CNT_W   (CNT_W),
        .TAP_BASE(TAP_BASE),
        .TAP_STEP(TAP_STEP)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (cnt_tick),
        .clr  (clr_w),
        .sel  (sel_w),
        .cnt  (cnt_w),
        .ovf  (ovf_w)
    );

    ivt_ctrl #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_we   (reg_we),
        .reg_wdata(reg_wdata),
        .ovf      (ovf_w),
        .reg_rdata(reg_rdata),
        .clr      (clr_w),
        .sel      (sel_w),
        .flag     (flag_w),
        .ien      (ien_w),
        .irq      (irq)
    );
endmodule

// File: rtl/ivt_chk.sv
module ivt_chk
    import ivt_pkg::*;
#(
    parameter int                CNT_W     = 22,
    parameter int                ADDR_W    = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_tick,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic              ovf,
    input logic              clr,
    input logic              flag,
    input logic              ien
);
    logic wr;
    assign wr = reg_we && (reg_addr == CTRL_ADDR);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick && !clr |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_tick && !clr |=> $stable(cnt)); // R1
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0); // R7
    AST_FLAG_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !clr |=> flag); // R3
    AST_CLR_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && clr && !flag |=> !flag); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !(wr && !reg_wdata[FLAG_BIT]) |=> flag); // R5
    AST_W1_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        !flag && !ovf |=> !flag); // R9
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !reg_wdata[IEN_BIT] |=> !irq); // R4
    AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag && ien); // R4
    AST_ENABLE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        wr && reg_wdata[IEN_BIT] && reg_wdata[FLAG_BIT] && flag |=> irq); // R6
    AST_ATOMIC_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr && reg_wdata[IEN_BIT] && !reg_wdata[FLAG_BIT] && !ovf |=> !irq); // R8
    AST_RD_CLRN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == CTRL_ADDR |-> reg_rdata[CLRN_BIT]); // R10
    AST_RD_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr != CTRL_ADDR |-> reg_rdata == 8'h00); // R10
endmodule

bind ivt_top ivt_chk #(
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_tick (cnt_tick),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq      (irq),
    .cnt      (cnt_w),
    .ovf      (ovf_w),
    .clr      (clr_w),
    .flag     (flag_w),
    .ien      (ien_w)
);

// File: tb/sim_ivt_top.sv
`timescale 1ns/1ps
module sim_ivt_top;
    localparam int CNT_W    = 8;
    localparam int TAP_BASE = 2;
    localparam int TAP_STEP = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_tick = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R11";

    // behavioural reference state
    int m_cnt = 0, m_flag = 0, m_ien = 0, m_sel = 0;

    always #2.5 clk = ~clk;

    ivt_top #(
        .CNT_W(CNT_W), .TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP),
        .ADDR_W(2), .CTRL_ADDR(2'd0)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_flag = 0; m_ien = 0; m_sel = 0;
        end else begin
            bit wr, clr, wrap;
            int tap, mask;
            wr   = reg_we && reg_addr == 2'd0;
            clr  = wr && !reg_wdata[5];
            tap  = TAP_BASE + m_sel * TAP_STEP;
            mask = (1 << (tap + 1)) - 1;
            wrap = cnt_tick && ((m_cnt & mask) == mask);
            if (clr) m_cnt = 0;
            else if (cnt_tick) m_cnt = (m_cnt + 1) % (1 << CNT_W);
            if (wr) begin
                m_ien = reg_wdata[6];
                m_sel = reg_wdata[1:0];
                if (!reg_wdata[7]) m_flag = 0;
            end
            if (wrap && !clr) m_flag = 1;
        end
    end

    function automatic logic [7:0] exp_rd();
        if (reg_addr != 2'd0) return 8'h00;
        return {m_flag[0], m_ien[0], 1'b1, 3'b000, m_sel[1:0]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, reg_rdata, exp_rd());
            chk(cur_req, {7'd0, irq}, {7'd0, (m_flag != 0 && m_ien != 0)});
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            finish_run();
        end
    end

    task automatic cyc(input logic we, input logic [1:0] a, input logic [7:0] d, input logic t);
        @(posedge clk); #1;
        reg_we = we; reg_addr = a; reg_wdata = d; cnt_tick = t;
    endtask

    task automatic idle(input logic t);
        cyc(1'b0, 2'd0, 8'h00, t);
    endtask

    task automatic wait_wrap(input int mask);
        for (int i = 0; i < 300 && (m_cnt & mask) != mask; i++) idle(1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset values visible before any edge with reset released
        chk("R11", reg_rdata, 8'h20);
        chk("R11", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;

        // R3: overflow with the interrupt disabled still sets the flag
        cur_req = "R3";
        for (int i = 0; i < 10; i++) idle(1'b1);
        idle(1'b0);
        @(negedge clk);
        chk("R3", reg_rdata, 8'hA0);
        chk("R3", {7'd0, irq}, 8'h00);

        // R9: writing 1 to the flag while it is 0 does nothing
        cur_req = "R9";
        cyc(1'b1, 2'd0, 8'h20, 1'b0);   // clear flag
        cyc(1'b1, 2'd0, 8'h80, 1'b0);   // clears counter, flag write 1
        idle(1'b0);
        @(negedge clk);
        chk("R9", reg_rdata, 8'h20);

        // R8: flag set, then one write enables and clears together
        cur_req = "R8";
        for (int i = 0; i < 9; i++) idle(1'b1);
        idle(1'b0);
        @(negedge clk);
        chk("R8", reg_rdata, 8'hA0);
        cyc(1'b1, 2'd0, 8'h60, 1'b0);
        idle(1'b0);
        @(negedge clk);
        chk("R8", {7'd0, irq}, 8'h00);
        chk("R8", reg_rdata, 8'h60);

        // R6: enable raised while flag already 1
        cur_req = "R6";
        cyc(1'b1, 2'd0, 8'hA0, 1'b0);   // ien=0, keep flag
        for (int i = 0; i < 10; i++) idle(1'b1);
        idle(1'b0);
        @(negedge clk);
        chk("R6", {7'd0, irq}, 8'h00);
        cyc(1'b1, 2'd0, 8'hE0, 1'b0);
        idle(1'b0);
        @(negedge clk);
        chk("R6", {7'd0, irq}, 8'h01);
        chk("R6", reg_rdata, 8'hE0);

        // R10: other address reads zero and ignores writes
        cur_req = "R10";
        cyc(1'b0, 2'd1, 8'h00, 1'b0);
        @(negedge clk);
        chk("R10", reg_rdata, 8'h00);
        cyc(1'b1, 2'd1, 8'h00, 1'b0);
        idle(1'b0);
        @(negedge clk);
        chk("R10", reg_rdata, 8'hE0);

        // R5: software clear drops irq
        cur_req = "R5";
        cyc(1'b1, 2'd0, 8'h60, 1'b0);
        idle(1'b0);
        @(negedge clk);
        chk("R5", {7'd0, irq}, 8'h00);

        // R4: irq follows flag and enable
        cur_req = "R4";
        for (int i = 0; i < 10; i++) idle(1'b1);
        idle(1'b0);
        @(negedge clk);
        chk("R4", {7'd0, irq}, 8'h01);
        cyc(1'b1, 2'd0, 8'hA0, 1'b0);
        idle(1'b0);
        @(negedge clk);
        chk("R4", {7'd0, irq}, 8'h00);

        // R5: clear of flag in the overflow cycle loses to the set
        cur_req = "R5";
        cyc(1'b1, 2'd0, 8'h20, 1'b0);
        wait_wrap(7);
        reg_we = 1'b1; reg_wdata = 8'h20; cnt_tick = 1'b1;
        idle(1'b0);
        @(negedge clk);
        chk("R5", reg_rdata, 8'hA0);

        // R7: counter clear in the overflow cycle suppresses the flag
        cur_req = "R7";
        cyc(1'b1, 2'd0, 8'h20, 1'b0);
        wait_wrap(7);
        reg_we = 1'b1; reg_wdata = 8'h80; cnt_tick = 1'b1;
        idle(1'b0);
        @(negedge clk);
        chk("R7", reg_rdata, 8'h20);
        for (int i = 0; i < 7; i++) idle(1'b1);
        idle(1'b0);
        @(negedge clk);
        chk("R7", reg_rdata, 8'h20);   // counter restarted at 0
        idle(1'b1);
        idle(1'b0);
        @(negedge clk);
        chk("R7", reg_rdata, 8'hA0);

        // R2: widest tap, exact tick count
        cur_req = "R2";
        cyc(1'b1, 2'd0, 8'h03, 1'b0);
        for (int i = 0; i < 63; i++) idle(1'b1);
        idle(1'b0);
        @(negedge clk);
        chk("R2", reg_rdata, 8'h23);
        idle(1'b1);
        idle(1'b0);
        @(negedge clk);
        chk("R2", reg_rdata, 8'hA3);

        // R1: irregular ticks over every tap with periodic acknowledges
        cur_req = "R1";
        for (int s = 0; s < 4; s++) begin
            cyc(1'b1, 2'd0, 8'h60 | 8'(s), 1'b0);
            for (int i = 0; i < 600; i++) begin
                if (i % 97 == 96) cyc(1'b1, 2'd0, 8'h60 | 8'(s), 1'($urandom_range(0, 1)));
                else idle(1'($urandom_range(0, 3) != 0));
            end
        end
        idle(1'b0);
        @(negedge clk);
        finish_run();
    end
endmodule